// File: doc/BRIEF.md
# Receive FIFO with Threshold Flag and RTS Flow Control

This block buffers bytes arriving from a UART receiver in a 64-entry FIFO and lets the CPU take them out one at a time. A registered occupancy count drives two threshold outputs. The first is a "receive data ready" flag for the CPU. The second is the RTS flow-control line, which tells the remote sender to pause. Each output has its own programmable level, chosen from a fixed table.

A 16-bit control register holds both level selectors and a set of side controls. These are a receive-clear bit, a transmit-clear bit, a modem-control enable, a loopback enable and a 2-bit transmit trigger field. The transmit-side bits are only stored here. They are exported unchanged to a neighbouring transmit path. The register is written through a simple write strobe and can always be read back.

Top module: `rx_fifo_thresh`

## Requirements
- R1: After synchronous reset the register reads 0x0000, the count is 0, and `rx_ready` and `rts_out` are low. This gives an RTS level of 63 and a flag level of 1.
- R2: Register bits 15:11 always read 0, and writing ones to them has no effect.
- R3: Bits 7:6 select the flag level: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 48. `rx_ready` is high when count is greater than or equal to the level.
- R4: Bits 10:8 select the RTS level: 000 gives 63, 001 gives 1, 010 gives 8, 011 gives 16, 100 gives 32, 101 gives 48, 110 gives 54 and 111 gives 60. `rts_out` is high only when count is strictly greater than the level.
- R5: While the modem-control enable (bit 3) is 0, `rts_out` stays low whatever the count.
- R6: Bytes are popped in the order they were pushed, up to 64 stored bytes. The count rises by one on each accepted push and falls by one on each accepted pop.
- R7: A push while 64 bytes are stored is dropped, and `overrun` is high for exactly the next cycle. The count never exceeds 64.
- R8: A pop while empty returns 0x00 on `pop_data` and leaves the count unchanged.
- R9: While the receive-clear bit (bit 1) is 1, the count is held at 0, pushes are discarded without overrun, and pops return 0x00. Normal operation resumes once the bit is written back to 0.
- R10: The loopback bit (bit 0), the transmit-clear bit (bit 2) and the transmit trigger field (bits 5:4) read back as written and appear on `loop_en`, `tx_clear` and `tx_trig`.
- R11: `rx_ready` and `rts_out` reflect the new count in the first cycle after the clock edge that accepts a push, pop or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Receiver offers a byte this cycle |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | CPU takes the oldest byte this cycle |
| pop_data | output | 8 | Oldest byte while popping, else 0 |
| overrun | output | 1 | One-cycle pulse after a dropped push |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write value |
| reg_rdata | output | 16 | Control register read value |
| rx_count | output | 7 | Stored byte count, 0 to 64 |
| rx_ready | output | 1 | Count at or above the flag level |
| rts_out | output | 1 | Count above the RTS level, with modem control on |
| loop_en | output | 1 | Loopback select for the transmit path |
| tx_clear | output | 1 | Transmit count clear level |
| tx_trig | output | 2 | Transmit trigger field |

## Verification
The bench targets the places where the two comparisons differ: a count exactly equal to a level, where the flag must rise but RTS must stay low. A design that swapped `>` and `>=` would light RTS one byte early or miss the flag by one. The irregular RTS entries (54, 60 and the 63 of code 000) are each exercised at their edge, so a table compiled in a tidy power-of-two order would show up as a wrong RTS. The bench also fills the FIFO to 64 and pushes once more, pops while empty, and pushes while the clear bit is held. A design that wrapped the count, returned stale data, or let bytes slip in during clear would show a wrong count, wrong data or a spurious overrun.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    parameter int unsigned RXQ_DEPTH  = 64;
    parameter int unsigned RXQ_DATA_W = 8;
    localparam int unsigned RXQ_CNT_W = $clog2(RXQ_DEPTH + 1);

    typedef logic [RXQ_CNT_W-1:0] rxq_cnt_t;

    // Control register layout; field positions are decoded by neighbours.
    typedef struct packed {
        logic [4:0] rsvd;      // 15:11 read as zero
        logic [2:0] rts_sel;   // 10:8
        logic [1:0] flag_sel;  // 7:6
        logic [1:0] tx_trig;   // 5:4
        logic       mce;       // 3
        logic       tx_clr;    // 2
        logic       rx_clr;    // 1
        logic       loop_en;   // 0
    } rxq_ctrl_t;

    function automatic rxq_cnt_t rxq_rts_level(input logic [2:0] sel);
        case (sel)
            3'd0:    return rxq_cnt_t'(63);
            3'd1:    return rxq_cnt_t'(1);
            3'd2:    return rxq_cnt_t'(8);
            3'd3:    return rxq_cnt_t'(16);
            3'd4:    return rxq_cnt_t'(32);
            3'd5:    return rxq_cnt_t'(48);
            3'd6:    return rxq_cnt_t'(54);
            default: return rxq_cnt_t'(60);
        endcase
    endfunction

    function automatic rxq_cnt_t rxq_flag_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return rxq_cnt_t'(1);
            2'd1:    return rxq_cnt_t'(16);
            2'd2:    return rxq_cnt_t'(32);
            default: return rxq_cnt_t'(48);
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl_reg.sv
module rxq_ctrl_reg
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [15:0] wdata,
    output rxq_ctrl_t   ctrl,
    output logic [15:0] rdata
);

    rxq_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q      <= rxq_ctrl_t'(wdata);
            ctrl_q.rsvd <= '0;
        end
    end

    assign ctrl  = ctrl_q;
    assign rdata = ctrl_q;

    // R10: a write lands in the writable bits by the next cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr |=> rdata[10:0] == $past(wdata[10:0]));

    // R2: reserved bits stay zero after any write
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        wr |=> rdata[15:11] == 5'd0);

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    parameter int unsigned DATA_W = RXQ_DATA_W,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              overrun
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovr_q;
    logic              full, empty, push_ok, pop_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !clr && !full;
    assign pop_ok  = pop && !clr && !empty;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            ovr_q  <= 1'b0;
        end else begin
            ovr_q <= push && full;
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign pop_data = pop_ok ? mem[rd_ptr] : '0;
    assign count    = cnt_q;
    assign overrun  = ovr_q;

    // R7: count never passes the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R7: an overrun pulse follows a cycle in which the FIFO was full
    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(count == CNT_W'(DEPTH)));

    // R8: a lone pop on an empty FIFO leaves it empty
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count == '0) |=> count == '0);

    // R9: clear holds the count at zero
    a_r9_clear_holds: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !overrun));

    // R6: count moves by at most one per cycle unless cleared
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1
                  || count == $past(count) - 1'b1 || $past(clr)));

endmodule

// File: rtl/rxq_level_cmp.sv
module rxq_level_cmp
    import rxq_pkg::*;
(
    input  rxq_cnt_t   count,
    input  logic [2:0] rts_sel,
    input  logic [1:0] flag_sel,
    input  logic       mce,
    output logic       flag,
    output logic       rts
);

    rxq_cnt_t rts_lvl, flag_lvl;

    always_comb begin
        rts_lvl  = rxq_rts_level(rts_sel);
        flag_lvl = rxq_flag_level(flag_sel);
        flag     = (count >= flag_lvl);
        rts      = mce && (count > rts_lvl);
    end

endmodule

// File: rtl/rx_fifo_thresh.sv
module rx_fifo_thresh
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        push_valid,
    input  logic [7:0]  push_data,
    input  logic        pop_req,
    output logic [7:0]  pop_data,
    output logic        overrun,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [6:0]  rx_count,
    output logic        rx_ready,
    output logic        rts_out,
    output logic        loop_en,
    output logic        tx_clear,
    output logic [1:0]  tx_trig
);

    rxq_ctrl_t ctrl;
    rxq_cnt_t  count;

    rxq_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    rxq_store #(
        .DEPTH  (RXQ_DEPTH),
        .DATA_W (RXQ_DATA_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (ctrl.rx_clr),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (pop_req),
        .pop_data  (pop_data),
        .count     (count),
        .overrun   (overrun)
    );

    rxq_level_cmp u_cmp (
        .count    (count),
        .rts_sel  (ctrl.rts_sel),
        .flag_sel (ctrl.flag_sel),
        .mce      (ctrl.mce),
        .flag     (rx_ready),
        .rts      (rts_out)
    );

    assign rx_count = count;
    assign loop_en  = ctrl.loop_en;
    assign tx_clear = ctrl.tx_clr;
    assign tx_trig  = ctrl.tx_trig;

    // R4: RTS can only be raised with at least two bytes stored
    a_r4_rts_needs_data: assert property (@(posedge clk) disable iff (rst)
        rts_out |-> count >= rxq_cnt_t'(2));

    // R5: modem control off keeps RTS low
    a_r5_rts_gated: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[3] |-> !rts_out);

    // R3: the flag is never set on an empty FIFO
    a_r3_flag_needs_data: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> count != '0);

endmodule

// File: tb/test_rx_fifo_thresh.sv
`timescale 1ns/1ps
module test_rx_fifo_thresh;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_valid, pop_req, reg_wr;
    logic [7:0]  push_data;
    logic [15:0] reg_wdata;
    logic [7:0]  pop_data;
    logic        overrun, rx_ready, rts_out, loop_en, tx_clear;
    logic [15:0] reg_rdata;
    logic [6:0]  rx_count;
    logic [1:0]  tx_trig;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rx_fifo_thresh i_rx_fifo_thresh (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .overrun(overrun),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_count(rx_count), .rx_ready(rx_ready), .rts_out(rts_out),
        .loop_en(loop_en), .tx_clear(tx_clear), .tx_trig(tx_trig)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [6:0]  fill;
        logic        exp_flag;
        logic        exp_rts;
    } vec_t;

    // ctrl value, bytes pushed, expected flag, expected RTS
    localparam vec_t VECS [16] = '{
        '{16'h0008, 7'd0,  1'b0, 1'b0},
        '{16'h0008, 7'd1,  1'b1, 1'b0},
        '{16'h0008, 7'd63, 1'b1, 1'b0},
        '{16'h0008, 7'd64, 1'b1, 1'b1},
        '{16'h0108, 7'd1,  1'b1, 1'b0},
        '{16'h0108, 7'd2,  1'b1, 1'b1},
        '{16'h0048, 7'd15, 1'b0, 1'b0},
        '{16'h0048, 7'd16, 1'b1, 1'b0},
        '{16'h0288, 7'd9,  1'b0, 1'b1},
        '{16'h0288, 7'd32, 1'b1, 1'b1},
        '{16'h06C8, 7'd54, 1'b1, 1'b0},
        '{16'h06C8, 7'd55, 1'b1, 1'b1},
        '{16'h0708, 7'd60, 1'b1, 1'b0},
        '{16'h0708, 7'd61, 1'b1, 1'b1},
        '{16'h0308, 7'd17, 1'b1, 1'b1},
        '{16'h0100, 7'd40, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push_n(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_valid = 1'b1; push_data = base + 8'(i);
        end
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic flush(input logic [15:0] ctrl);
        wr_reg(ctrl | 16'h0002);
        @(negedge clk);
        wr_reg(ctrl & ~16'h0002);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; push_valid = 0; pop_req = 0; reg_wr = 0;
        push_data = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 reg", reg_rdata, 0);
        chk("R1 count", rx_count, 0);
        chk("R1 flag", rx_ready, 0);
        chk("R1 rts", rts_out, 0);

        // threshold table walk
        for (int v = 0; v < 16; v++) begin
            flush(VECS[v].ctrl);
            chk("R9 flushed", rx_count, 0);
            if (VECS[v].fill != 0) push_n(int'(VECS[v].fill), 8'h00);
            else @(negedge clk);
            chk("R6 fill count", rx_count, int'(VECS[v].fill));
            chk("R3 flag", rx_ready, VECS[v].exp_flag);
            chk(VECS[v].ctrl[3] ? "R4 rts" : "R5 rts", rts_out, VECS[v].exp_rts);
        end

        // R2: reserved bits ignored; R10: side bits exported
        wr_reg(16'hFFF5);
        chk("R2 readback", reg_rdata, 16'h07F5);
        chk("R10 loop", loop_en, 1);
        chk("R10 txclr", tx_clear, 1);
        chk("R10 trig", tx_trig, 3);
        wr_reg(16'h0020);
        chk("R10 trig2", tx_trig, 2);
        chk("R10 loop off", loop_en, 0);

        // R11 + R6: ordered data, flag on the cycle after the push
        flush(16'h0000);
        @(negedge clk);
        push_valid = 1'b1; push_data = 8'hA5;
        @(negedge clk);
        push_valid = 1'b0;
        chk("R11 flag next cycle", rx_ready, 1);
        push_n(3, 8'h10);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pop_req = 1'b1;
            #1 chk("R6 order", pop_data, (i == 0) ? 8'hA5 : 8'h10 + i - 1);
        end
        @(negedge clk);
        pop_req = 1'b0;
        chk("R11 flag after pops", rx_ready, 0);
        chk("R6 drained", rx_count, 0);

        // R8: pop on empty
        pop_req = 1'b1;
        #1 chk("R8 empty data", pop_data, 0);
        @(negedge clk);
        pop_req = 1'b0;
        chk("R8 count", rx_count, 0);

        // R7: overrun
        push_n(64, 8'h40);
        chk("R7 full", rx_count, 64);
        @(negedge clk);
        push_valid = 1'b1; push_data = 8'hEE;
        @(negedge clk);
        push_valid = 1'b0;
        chk("R7 overrun pulse", overrun, 1);
        chk("R7 count capped", rx_count, 64);
        @(negedge clk);
        chk("R7 pulse ends", overrun, 0);
        pop_req = 1'b1;
        #1 chk("R7 head intact", pop_data, 8'h40);
        @(negedge clk);
        pop_req = 1'b0;

        // R9: clear discards pushes, pops give 0
        wr_reg(16'h0002);
        @(negedge clk);
        chk("R9 cleared", rx_count, 0);
        push_n(5, 8'h77);
        chk("R9 discard", rx_count, 0);
        chk("R9 no overrun", overrun, 0);
        pop_req = 1'b1;
        #1 chk("R9 pop zero", pop_data, 0);
        @(negedge clk);
        pop_req = 1'b0;
        wr_reg(16'h0000);
        push_n(1, 8'h3C);
        chk("R9 resumed", rx_count, 1);
        pop_req = 1'b1;
        #1 chk("R9 resumed data", pop_data, 8'h3C);
        @(negedge clk);
        pop_req = 1'b0;

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule